// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycles of a processor core. The address is 16 bits wide. The upper address byte has its own outputs. The lower address byte and the 8-bit data share one bidirectional pad group, which is modelled here as an output value, an output enable and an input value. The core places a request: an address, a read or write flag, a memory or I/O flag and a write byte. The controller then steps through four bus states, T1 to T4. It produces the address-latch strobe, active-low read and write strobes and the memory/I-O select, and it returns the captured read byte together with a one-clock completion pulse.

Each bus state lasts two cycles of the input clock. A clock output at half the input frequency marks the bus-state rhythm. An external DMA master can request the bus with `hold`. The controller samples that request only between bus cycles. It then floats every address, data and control output and raises `hlda` until the request is withdrawn.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, every strobe is inactive: `ale`=0, `rd_n`=1, `wr_n`=1, `done`=0, `hlda`=0, and neither `ad_oe` nor `addr_hi_oe` is set. `reset_out` reads 1 from the first clock edge of reset and drops to 0 one clock after `rst_n` is released.
- R2: `clk_out` changes value on every rising edge of `clk`, so its frequency is half that of `clk`.
- R3: Each bus state lasts two clocks. During both clocks of T1: `ale`=1; `addr_hi` shows address bits 15:8 with `addr_hi_oe`=1; `ad_out` shows address bits 7:0 with `ad_oe`=1; `io_m` equals the request's I/O flag (1 = I/O, 0 = memory).
- R4: `ale` is 0 in T2, T3 and T4, so that its falling edge separates the address phase from the data phase.
- R5: For a read, `rd_n` is low for all of T2 and T3. `ad_oe` stays 0 from T2 until the end of T4. The byte on `ad_in` at the last clock edge of T3 appears on `rd_data` from T4 onward.
- R6: For a write, `wr_n` is low for all of T2 and T3. `ad_out` carries the write byte with `ad_oe`=1 from T2 through the first clock of T4. `ad_oe` returns to 0 in the second clock of T4.
- R7: In T4, `rd_n` and `wr_n` are both 1. `done` is 1 for exactly the first clock of T4.
- R8: `rd_n` and `wr_n` are never low at the same time.
- R9: `hold` is sampled only when a cycle ends or the bus is idle. An access already in progress finishes all of T2 to T4 before `hlda` rises.
- R10: While `hlda`=1: `ctl_oe`=0, `ad_oe`=0 and `addr_hi_oe`=0. `hlda` falls at the next bus-state boundary after `hold` returns to 0, which is at most two clocks later.
- R11: A request is taken (`req_ready`=1) only on the last clock of an idle state or of T4, and only while `hold`=0. A request pending at the end of T4 starts its T1 at once, with no idle state between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core has a bus request pending |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request taken on this clock edge |
| done | output | 1 | One-clock pulse at the start of T4 |
| rd_data | output | 8 | Byte captured by the last read |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for `addr_hi` |
| ad_out | output | 8 | Value driven onto the shared address/data pads |
| ad_oe | output | 1 | Drive enable for the shared pads |
| ad_in | input | 8 | Value read from the shared pads |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| ctl_oe | output | 1 | Drive enable for the control strobes |
| hold | input | 1 | Bus request from an external DMA master |
| hlda | output | 1 | Bus granted to the DMA master |
| clk_out | output | 1 | Clock at half the oscillator frequency |
| reset_out | output | 1 | High while the controller is held in reset |

## Verification
Two situations are hard to reach from the ports. The first is a `hold` request that arrives in the middle of an access. The bench raises `hold` in T2 of a read. It then checks that T3 and T4 keep their strobes and the completion pulse, and that the grant appears only after T4. The second is the back-to-back case. The bench presents the next request during T4, so the controller must move from T4 straight to T1. To find the right clocks, the bench first waits for `req_ready`. It then counts clocks from that handshake, so every state can be sampled in a known clock.

// File: rtl/bcc_pkg.sv
// Package for the multiplexed bus cycle controller.
// Holds the bus-state encoding that the sequencer and the pad decoder share.
package bcc_pkg;
    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4,
        TS_HOLD = 3'd5
    } tstate_e;
endpackage

// File: rtl/bcc_clkdiv.sv
// Phase divider. Splits each bus state into two oscillator clocks.
// step is high in the second clock, when the sequencer may advance.
// clk_out runs at half the oscillator rate.
// Also registers the reset-out indication.
// Assumes a synchronous active-low reset.
module bcc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic step,
    output logic clk_out,
    output logic reset_out
);
    logic ph_q;

    // Purpose: toggle the phase bit on every clock and hold it at 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    // Purpose: report the reset condition to external devices.
    always_ff @(posedge clk) begin
        reset_out <= ~rst_n;
    end

    assign step    = ph_q;
    assign clk_out = ~ph_q;

    // R2: the output clock changes on every edge.
    p_clk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clk_out != $past(clk_out)));
endmodule

// File: rtl/bcc_seq.sv
// Bus-state sequencer. Takes requests, steps from T1 to T4 and grants the bus
// to a DMA master. Advances only when step is high.
// Assumes the core holds req_* stable until req_ready is seen.
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hold,
    output tstate_e           state,
    output logic              req_ready,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic              cur_io,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              hlda
);
    logic at_boundary;

    // Purpose: mark the states where a new cycle or a grant may begin.
    always_comb begin
        at_boundary = (state == TS_IDLE) || (state == TS_T4);
    end

    assign req_ready = step && req_valid && !hold && at_boundary;
    assign hlda      = (state == TS_HOLD);

    // Purpose: advance the bus state and latch the request when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TS_IDLE;
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_io    <= 1'b0;
            cur_wdata <= '0;
        end else if (step) begin
            case (state)
                TS_IDLE, TS_T4: begin
                    if (hold) begin
                        state <= TS_HOLD;
                    end else if (req_valid) begin
                        state     <= TS_T1;
                        cur_addr  <= req_addr;
                        cur_write <= req_write;
                        cur_io    <= req_io;
                        cur_wdata <= req_wdata;
                    end else begin
                        state <= TS_IDLE;
                    end
                end
                TS_T1:   state <= TS_T2;
                TS_T2:   state <= TS_T3;
                TS_T3:   state <= TS_T4;
                TS_HOLD: if (!hold) state <= TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end

    // R9: the grant begins only after an idle state or a T4.
    p_grant_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(state == TS_IDLE || state == TS_T4));
    // R10: the grant ends at the first boundary after hold drops.
    p_hlda_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold && step) |=> !hlda);
    // R11: no request is taken while hold is asserted.
    p_no_accept_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !req_ready);
endmodule

// File: rtl/bcc_pads.sv
// Pad decoder. Turns the bus state and the latched request into strobes,
// drive enables and pad values, and captures the read byte at the end of T3.
// Assumes step is high in the second clock of each bus state.
module bcc_pads
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  tstate_e                  state,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic                     cur_write,
    input  logic                     cur_io,
    input  logic [DATA_W-1:0]        cur_wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_hi_oe,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     ctl_oe,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data
);
    logic in_cycle;
    logic strobe_win;

    // Purpose: decode the cycle-wide and strobe windows from the bus state.
    always_comb begin
        in_cycle   = (state == TS_T1) || (state == TS_T2) ||
                     (state == TS_T3) || (state == TS_T4);
        strobe_win = (state == TS_T2) || (state == TS_T3);
    end

    // Purpose: drive the address, data, strobes and enables for each bus state.
    always_comb begin
        addr_hi    = cur_addr[ADDR_W-1:DATA_W];
        addr_hi_oe = in_cycle;
        ale        = (state == TS_T1);
        rd_n       = !(strobe_win && !cur_write);
        wr_n       = !(strobe_win && cur_write);
        io_m       = in_cycle && cur_io;
        ctl_oe     = (state != TS_HOLD);
        done       = (state == TS_T4) && !step;
        ad_oe      = (state == TS_T1) ||
                     (cur_write && (strobe_win || ((state == TS_T4) && !step)));
        ad_out     = (state == TS_T1) ? cur_addr[DATA_W-1:0] : cur_wdata;
    end

    // Purpose: capture the read byte on the last edge of T3.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      rd_data <= '0;
        else if (step && state == TS_T3 && !cur_write)   rd_data <= ad_in;
    end

    // R8: the read and write strobes never overlap.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R5: the pads are not driven while a read strobe is active.
    p_read_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R7: the completion pulse comes with both strobes high.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n));
    // R10: a released control group means nothing else is driven.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (!ad_oe && !addr_hi_oe));
    // R4: the address strobe never overlaps a read or write strobe.
    p_ale_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));
endmodule

// File: rtl/bus_cycle_ctrl.sv
// Top of the multiplexed bus cycle controller. Connects the phase divider,
// the bus-state sequencer and the pad decoder.
// The shared address/data pads are presented as separate out/enable/in ports.
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [HI_W-1:0]   addr_hi,
    output logic              addr_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              ctl_oe,
    input  logic              hold,
    output logic              hlda,
    output logic              clk_out,
    output logic              reset_out
);
    logic              step;
    tstate_e           state;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic              cur_io;
    logic [DATA_W-1:0] cur_wdata;

    bcc_clkdiv u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clk_out   (clk_out),
        .reset_out (reset_out)
    );

    bcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_io    (req_io),
        .req_wdata (req_wdata),
        .hold      (hold),
        .state     (state),
        .req_ready (req_ready),
        .cur_addr  (cur_addr),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .cur_wdata (cur_wdata),
        .hlda      (hlda)
    );

    bcc_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .state      (state),
        .cur_addr   (cur_addr),
        .cur_write  (cur_write),
        .cur_io     (cur_io),
        .cur_wdata  (cur_wdata),
        .ad_in      (ad_in),
        .addr_hi    (addr_hi),
        .addr_hi_oe (addr_hi_oe),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .io_m       (io_m),
        .ctl_oe     (ctl_oe),
        .done       (done),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
// Self-checking bench. A vector table drives one bus access per entry.
// Directed tests for reset, hold and back-to-back cycles follow.
module bus_cycle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, addr_hi_oe, ad_oe, ale, rd_n, wr_n, io_m;
    logic        ctl_oe, hlda, clk_out, reset_out;
    logic [7:0]  rd_data, addr_hi, ad_out;
    logic [7:0]  ad_in = '0;
    logic        hold = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .ctl_oe(ctl_oe), .hold(hold), .hlda(hlda),
        .clk_out(clk_out), .reset_out(reset_out)
    );

    // Vector fields: {write, io, addr[15:0], wdata[7:0], read byte[7:0]}
    localparam logic [33:0] VECS [6] = '{
        {1'b0, 1'b0, 16'h2005, 8'h00, 8'h4F},
        {1'b1, 1'b0, 16'h1234, 8'hA5, 8'h00},
        {1'b0, 1'b1, 16'h0081, 8'h00, 8'h3C},
        {1'b1, 1'b1, 16'h00FE, 8'h5A, 8'h00},
        {1'b0, 1'b0, 16'hFFFF, 8'h00, 8'hFF},
        {1'b1, 1'b0, 16'h0000, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        #1;
        for (int i = 0; i < 20 && !req_ready; i++) begin
            @(negedge clk);
            #1;
        end
        chk("R11 request taken", {31'd0, req_ready}, 32'd1);
    endtask

    // One access. hold_mid raises hold in T2; chain presents nv during T4;
    // skip_wait means the request was already taken at the end of the previous T4.
    task automatic do_access(input logic [33:0] v, input bit hold_mid,
                             input bit chain, input logic [33:0] nv,
                             input bit skip_wait);
        logic wr, io;
        logic [15:0] a;
        logic [7:0] wd, rv;
        wr = v[33]; io = v[32]; a = v[31:16]; wd = v[15:8]; rv = v[7:0];
        if (!skip_wait) begin
            req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
            req_valid = 1'b1;
            wait_ready();
        end
        // T1, first clock
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 ale in T1", {31'd0, ale}, 32'd1);
        chk("R3 high address", {24'd0, addr_hi}, {24'd0, a[15:8]});
        chk("R3 high address enable", {31'd0, addr_hi_oe}, 32'd1);
        chk("R3 low address drive", {23'd0, ad_oe, ad_out}, {23'd0, 1'b1, a[7:0]});
        chk("R3 io_m", {31'd0, io_m}, {31'd0, io});
        // T1, second clock
        @(negedge clk);
        chk("R3 ale two clocks", {31'd0, ale}, 32'd1);
        // T2, first clock
        @(negedge clk);
        if (hold_mid) hold = 1'b1;
        ad_in = rv;
        chk("R4 ale low in T2", {31'd0, ale}, 32'd0);
        chk("R5 rd_n in T2", {31'd0, rd_n}, {31'd0, wr});
        chk("R6 wr_n in T2", {31'd0, wr_n}, {31'd0, ~wr});
        chk("R5 R6 pad drive in T2", {31'd0, ad_oe}, {31'd0, wr});
        if (wr) chk("R6 write byte", {24'd0, ad_out}, {24'd0, wd});
        @(negedge clk);
        // T3, first clock
        @(negedge clk);
        chk("R9 R5 rd_n in T3", {31'd0, rd_n}, {31'd0, wr});
        chk("R6 wr_n in T3", {31'd0, wr_n}, {31'd0, ~wr});
        chk("R4 ale low in T3", {31'd0, ale}, 32'd0);
        @(negedge clk);
        // T4, first clock
        @(negedge clk);
        ad_in = ~rv;
        chk("R7 strobes high in T4", {30'd0, rd_n, wr_n}, 32'd3);
        chk("R7 done pulse", {31'd0, done}, 32'd1);
        chk("R6 pad held after WR rises", {31'd0, ad_oe}, {31'd0, wr});
        if (!wr) chk("R5 read byte", {24'd0, rd_data}, {24'd0, rv});
        if (hold_mid) chk("R9 no grant before cycle end", {31'd0, hlda}, 32'd0);
        if (chain) begin
            req_write = nv[33]; req_io = nv[32]; req_addr = nv[31:16];
            req_wdata = nv[15:8]; req_valid = 1'b1;
        end
        // T4, second clock
        @(negedge clk);
        chk("R7 done one clock", {31'd0, done}, 32'd0);
        chk("R6 pad released", {31'd0, ad_oe}, 32'd0);
        if (chain) chk("R11 taken at end of T4", {31'd0, req_ready}, 32'd1);
        if (hold_mid) begin
            @(negedge clk);
            chk("R9 grant after T4", {31'd0, hlda}, 32'd1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic c0;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset_out", {31'd0, reset_out}, 32'd1);
        chk("R1 strobes in reset", {26'd0, ale, rd_n, wr_n, done, hlda, ad_oe},
            {26'd0, 6'b011000});
        chk("R1 high address released", {31'd0, addr_hi_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset_out cleared", {31'd0, reset_out}, 32'd0);
        c0 = clk_out;
        @(negedge clk);
        chk("R2 clk_out toggles", {31'd0, clk_out}, {31'd0, ~c0});
        c0 = clk_out;
        @(negedge clk);
        chk("R2 clk_out toggles again", {31'd0, clk_out}, {31'd0, ~c0});

        foreach (VECS[i]) do_access(VECS[i], 1'b0, 1'b0, '0, 1'b0);

        // Back-to-back: second request taken at the end of T4, no idle state.
        do_access(VECS[0], 1'b0, 1'b1, VECS[1], 1'b0);
        do_access(VECS[1], 1'b0, 1'b0, '0, 1'b1);

        // Hold while idle.
        repeat (4) @(negedge clk);
        hold = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 grant while idle", {31'd0, hlda}, 32'd1);
        chk("R10 outputs released", {29'd0, ctl_oe, ad_oe, addr_hi_oe}, 32'd0);
        req_write = 1'b0; req_io = 1'b0; req_addr = 16'h4000; req_valid = 1'b1;
        n = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (req_ready) n++;
        end
        chk("R11 no request taken during hold", n, 32'd0);
        chk("R10 grant persists", {31'd0, hlda}, 32'd1);
        hold = 1'b0;
        n = 0;
        for (int k = 0; k < 4 && hlda; k++) begin
            @(negedge clk);
            n++;
        end
        chk("R10 hlda drops within two clocks", {31'd0, n <= 2}, 32'd1);
        do_access({1'b0, 1'b0, 16'h4000, 8'h00, 8'h96}, 1'b0, 1'b0, '0, 1'b0);

        // Hold raised mid-access: the cycle completes and the grant follows.
        do_access({1'b0, 1'b1, 16'h0042, 8'h00, 8'hC3}, 1'b1, 1'b0, '0, 1'b0);
        chk("R10 released under grant", {29'd0, ctl_oe, ad_oe, addr_hi_oe}, 32'd0);
        hold = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 grant removed", {31'd0, hlda}, 32'd0);

        // Reset in the middle of a cycle.
        req_write = 1'b1; req_addr = 16'h7777; req_wdata = 8'h11; req_valid = 1'b1;
        wait_ready();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-cycle strobes", {27'd0, ale, rd_n, wr_n, ad_oe, addr_hi_oe},
            {27'd0, 5'b01100});
        chk("R1 reset_out mid-cycle", {31'd0, reset_out}, 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule